// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Multiplier

This block multiplies two square matrices of signed integers on a grid of N×N multiply-accumulate cells. Each cell owns one element of the result and keeps its running sum in place while operands stream past it. The left matrix enters along the left edge and moves one cell to the right per clock. The right matrix enters along the top edge and moves one cell down per clock. Each edge row or column is delayed by its index, so the matching elements of the two matrices meet in the cell that owns their product.

A one-cycle `start` in the idle state captures both matrices and clears every sum. After the last product has been folded in, zeros keep flowing in. The block then turns the grid into a column of shift registers and pushes the result out through the bottom edge, one row per cycle, bottom row first. A single-cycle `done` follows the last row. A `start` that arrives while the block is busy is ignored.

Top module: `mac_grid_matmul`

## Requirements
- R1: After reset, `busy`, `out_valid` and `done` are 0, and they stay 0 until a start is accepted.
- R2: Each emitted row holds the exact signed product C = A×B. Row i has C[i][j] = Σk A[i][k]·B[k][j], and C[i][j] sits in `out_row` bits [j*AW +: AW] as two's complement. A[i][k] is read from `a_mat` bits [(i*N+k)*DW +: DW], and B[k][j] from `b_mat` bits [(k*N+j)*DW +: DW], both signed.
- R3: Rows leave bottom first. `out_idx` is N-1 on the first valid cycle and falls by one on each following valid cycle, ending at 0.
- R4: `out_valid` first rises exactly 3N-2 cycles after the cycle in which start was accepted, and it stays high for exactly N consecutive cycles.
- R5: `done` is high for exactly one cycle, the cycle right after the row with index 0. In the cycle after that, `busy` is 0.
- R6: A `start` raised while `busy` is 1 (including the `done` cycle) has no effect. The running job keeps its matrices and its timing, and no new job begins.
- R7: Every accepted start clears all sums, so a job started right after the previous one gives results that do not depend on it.
- R8: The largest values are exact. With N=4, DW=8 and AW=20, all operands at -128 give 65536 in every element, and -128 against 127 gives -65024.
- R9: `busy` is 1 from the cycle after start is accepted through the `done` cycle inclusive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job when idle |
| a_mat | input | N*N*DW | Left matrix, row-major, signed elements |
| b_mat | input | N*N*DW | Right matrix, row-major, signed elements |
| busy | output | 1 | A job is in progress |
| out_valid | output | 1 | `out_row` carries a result row |
| out_idx | output | $clog2(N) | Index of the row on `out_row` |
| out_row | output | N*AW | One result row, element j at [j*AW +: AW] |
| done | output | 1 | One-cycle pulse after the last row |

## Verification
The bench goes after the skew and flush timing. If the edge delays are off by a cycle, or the zero flush is cut short, the far cells miss their last products and the bottom-right elements come out wrong, while the top-left elements still look correct. Operands at full negative scale show whether the product is sign-extended before it is added, because a zero-extended product makes every sum a large positive number. A start raised partway through a job, and another raised in the `done` cycle, show whether the block relatches its inputs or restarts. A job started right after the previous one shows whether the sums are cleared, because stale sums would add the earlier result to the new one.

// File: rtl/mac_grid_matmul.sv
module mac_grid_matmul #(
  parameter int N  = 4,
  parameter int DW = 8,
  parameter int AW = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [N*N*DW-1:0]       a_mat,
  input  logic [N*N*DW-1:0]       b_mat,
  output logic                    busy,
  output logic                    out_valid,
  output logic [((N>1)?$clog2(N):1)-1:0] out_idx,
  output logic [N*AW-1:0]         out_row,
  output logic                    done
);
  localparam int CW = $clog2(3*N);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] FEED_LAST  = CW'(3*N-3);
  localparam logic [CW-1:0] DRAIN_LAST = CW'(N-1);

  typedef enum logic [1:0] {S_IDLE, S_FEED, S_DRAIN, S_DONE} st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic [N*N*DW-1:0] a_q, b_q;
  logic signed [DW-1:0] left_in [N];
  logic signed [DW-1:0] top_in  [N];
  logic signed [DW-1:0] a_pipe  [N][N-1];
  logic signed [DW-1:0] b_pipe  [N-1][N];
  logic signed [AW-1:0] acc     [N][N];

  wire accept = (st == S_IDLE) && start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
      a_q <= '0;
      b_q <= '0;
    end else begin
      case (st)
        S_IDLE:  if (start) begin st <= S_FEED; cnt <= '0; a_q <= a_mat; b_q <= b_mat; end
        S_FEED:  if (cnt == FEED_LAST) begin st <= S_DRAIN; cnt <= '0; end else cnt <= cnt + 1'b1;
        S_DRAIN: if (cnt == DRAIN_LAST) begin st <= S_DONE; cnt <= '0; end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      left_in[i] = '0;
      top_in[i]  = '0;
      if (st == S_FEED && int'(cnt) >= i && int'(cnt) - i < N) begin
        left_in[i] = a_q[(i*N + int'(cnt) - i)*DW +: DW];
        top_in[i]  = b_q[((int'(cnt) - i)*N + i)*DW +: DW];
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      logic signed [DW-1:0]   x_in, y_in;
      logic signed [2*DW-1:0] prod;
      logic signed [AW-1:0]   up_acc;

      if (j == 0) begin : g_xe
        assign x_in = left_in[i];
      end else begin : g_xp
        assign x_in = a_pipe[i][j-1];
      end
      if (i == 0) begin : g_ye
        assign y_in   = top_in[j];
        assign up_acc = '0;
      end else begin : g_yp
        assign y_in   = b_pipe[i-1][j];
        assign up_acc = acc[i-1][j];
      end

      assign prod = x_in * y_in;

      always_ff @(posedge clk) begin
        if (!rst_n || accept)      acc[i][j] <= '0;
        else if (st == S_FEED)     acc[i][j] <= acc[i][j] + {{(AW-2*DW){prod[2*DW-1]}}, prod};
        else if (st == S_DRAIN)    acc[i][j] <= up_acc;
      end

      if (j < N-1) begin : g_ax
        always_ff @(posedge clk) begin
          if (!rst_n || accept)  a_pipe[i][j] <= '0;
          else if (st == S_FEED) a_pipe[i][j] <= x_in;
        end
      end
      if (i < N-1) begin : g_by
        always_ff @(posedge clk) begin
          if (!rst_n || accept)  b_pipe[i][j] <= '0;
          else if (st == S_FEED) b_pipe[i][j] <= y_in;
        end
      end
    end
    assign out_row[i*AW +: AW] = acc[N-1][i];
  end

  assign busy      = (st != S_IDLE);
  assign out_valid = (st == S_DRAIN);
  assign done      = (st == S_DONE);
  assign out_idx   = IW'(N-1) - cnt[IW-1:0];

  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!out_valid && !done));

  p_row_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> (out_idx == $past(out_idx) - 1'b1));

  p_first_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (out_idx == IW'(N-1)));

  p_feed_span_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> ($past(st) == S_FEED && $past(cnt) == FEED_LAST));

  p_done_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(out_valid) && $past(out_idx) == '0));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
endmodule

// File: tb/mac_grid_matmul_tb_top.sv
`timescale 1ns/1ps
module mac_grid_matmul_tb_top;
  localparam int N = 4, DW = 8, AW = 20;
  localparam int IW = $clog2(N);

  logic clk = 0, rst_n = 0, start = 0;
  logic [N*N*DW-1:0] a_mat = '0, b_mat = '0;
  logic busy, out_valid, done;
  logic [IW-1:0] out_idx;
  logic [N*AW-1:0] out_row;

  int checks = 0, errors = 0;
  int ma [N][N];
  int mb [N][N];

  always #4 clk = ~clk;

  mac_grid_matmul #(.N(N), .DW(DW), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .a_mat(a_mat), .b_mat(b_mat),
    .busy(busy), .out_valid(out_valid), .out_idx(out_idx), .out_row(out_row), .done(done));

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [N*N*DW-1:0] pack_a();
    logic [N*N*DW-1:0] v;
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) v[(i*N+j)*DW +: DW] = DW'(ma[i][j]);
    return v;
  endfunction

  function automatic logic [N*N*DW-1:0] pack_b();
    logic [N*N*DW-1:0] v;
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) v[(i*N+j)*DW +: DW] = DW'(mb[i][j]);
    return v;
  endfunction

  function automatic int exp_c(int i, int j);
    int s = 0;
    for (int k = 0; k < N; k++) s += ma[i][k] * mb[k][j];
    return s;
  endfunction

  task automatic run(input bit poke, input string tag);
    int lat = 0;
    a_mat = pack_a(); b_mat = pack_b(); start = 1;
    @(negedge clk);
    start = 0;
    chk({"R9 busy after accept ", tag}, busy, 1);
    while (!out_valid && lat < 100) begin
      if (poke && lat == 3) begin
        a_mat = ~a_mat; b_mat = {N*N{8'h5A}}; start = 1;
      end else start = 0;
      @(negedge clk);
      lat++;
    end
    start = 0;
    chk({"R4 latency ", tag}, lat, 3*N-2);
    for (int r = 0; r < N; r++) begin
      int row = N-1-r;
      int bad = 0;
      longint act_e = 0, exp_e = 0;
      chk({"R4 out_valid ", tag}, out_valid, 1);
      chk({"R3 out_idx ", tag}, out_idx, row);
      for (int j = 0; j < N; j++) begin
        longint a = longint'($signed(out_row[j*AW +: AW]));
        if (!bad && a != exp_c(row, j)) begin bad = 1; act_e = a; exp_e = exp_c(row, j); end
      end
      chk(poke ? {"R6 R2 row ", tag} : {"R2 R7 R8 row ", tag}, act_e, exp_e);
      @(negedge clk);
    end
    chk({"R4 valid ends ", tag}, out_valid, 0);
    chk({"R5 done ", tag}, done, 1);
    chk({"R9 busy at done ", tag}, busy, 1);
    if (poke) begin a_mat = pack_a(); start = 1; end
    @(negedge clk);
    start = 0;
    chk({"R5 done single ", tag}, done, 0);
    chk({"R6 R5 idle after ", tag}, busy, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(7));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 busy reset", busy, 0);
    chk("R1 valid reset", out_valid, 0);
    chk("R1 done reset", done, 0);

    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) begin
      ma[i][j] = (i == j) ? 1 : 0; mb[i][j] = i*N + j - 7;
    end
    run(0, "identity");
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) begin ma[i][j] = -128; mb[i][j] = -128; end
    run(0, "R8 negmax");
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) mb[i][j] = 127;
    run(0, "R8 mixed");
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) begin ma[i][j] = 0; mb[i][j] = 0; end
    ma[N-1][N-1] = 3; mb[N-1][N-1] = -5;
    run(0, "R7 corner");
    for (int t = 0; t < 10; t++) begin
      for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) begin
        ma[i][j] = int'($urandom_range(0, 255)) - 128;
        mb[i][j] = int'($urandom_range(0, 255)) - 128;
      end
      run(t % 3 == 1, t % 3 == 1 ? "R6 random poke" : "random");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule